// File: doc/BRIEF.md
# TLB Maintenance Register Interface

This block is the software-facing front end of a translation lookaside buffer. It owns the entry storage and exposes it through a small register port. Software picks an entry with an index register and then reads or writes that entry's tag word and data word. Writing a tag word also stamps the entry with the current process identifier. Reading a tag word loads that entry's identifier back into the process-identifier register. A zone protection register holds sixteen two-bit access fields.

A write to the search register looks up the written address among all entries, as a read access at the current privilege level. The index register then receives either the matching entry number or a miss flag. A configuration input gives the translation level and the access level. Together they decide which register reads return data and which writes take effect.

Each read strobe returns its data on `reg_rdata` one clock later. Writes take effect at the clock edge where the strobe is sampled.

Top module: `tlb_maint_regs`

## Requirements
- R1: After the synchronous active-high reset, every register reads zero, and so does every entry's tag word, data word and identifier.
- R2: Register numbers are 0 process identifier, 1 zone, 2 index, 3 data word, 4 tag word, 5 search. Data-word and tag-word accesses target entry (index mod ENTRIES). Read data appears on `reg_rdata` one cycle after the read strobe.
- R3: Writing the tag word stores bits [7:0] of the process-identifier register as the entry's identifier. A permitted read of the tag word loads the process-identifier register with that identifier, zero-extended.
- R4: A permitted search write matches an entry when all of the following hold: tag bit 6 (valid) is set; the search value and tag bits [31:10] agree above the page size; and the entry identifier is zero or equals process identifier bits [7:0]. A user-mode search also skips an entry whose zone field is 0; the zone number is data-word bits [7:4], and zone z sits at zone register bits [31-2z:30-2z]. The search value's bits [9:0] are ignored. The lowest matching entry wins, and its number overwrites the index register.
- R5: A search with no match sets index bit 31 and leaves bits [30:0] unchanged.
- R6: When the translation level is below 2 or the access level is 0, every read returns 0 and every write is ignored.
- R7: Writes to the process-identifier, zone and search registers need access-level bit 1. Writes to the index, data word and tag word need only the condition of R6.
- R8: Reads of the process-identifier, zone, data-word and tag-word registers need access-level bit 0 and otherwise return 0. Index and search reads need only the condition of R6.
- R9: A search read returns the last permitted search write. Register numbers 6 and 7 read 0.
- R10: Tag bits [9:7] hold a size code n, and the page spans 1024*4^n bytes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_level | input | 2 | Configured translation level |
| cfg_access | input | 2 | Access level: bit 0 enables protected reads, bit 1 enables protected writes |
| priv_user | input | 1 | Current privilege is user mode |
| reg_num | input | 3 | Register number |
| reg_wr | input | 1 | Write strobe |
| reg_rd | input | 1 | Read strobe |
| reg_wdata | input | 32 | Write data |
| reg_rdata | output | 32 | Registered read data |

## Verification
The search is tried on several kinds of stored entry: a 1 KB page tied to one process identifier, a global 1 MB page, two overlapping valid entries, and an invalid entry. These separate the identifier rule, the size mask, lowest-index priority and the valid bit. Search values differ in the ignored offset bits and cross a page boundary, and a miss is compared against the index value kept from before. A user-mode search is run before and after the zone field is opened, which shows the zone check. The permission tests sweep the access level and translation level while observing registers that a leaked write would have changed.

// File: rtl/tlb_maint_pkg.sv
package tlb_maint_pkg;
  typedef enum logic [2:0] {
    RN_PID    = 3'd0,
    RN_ZONE   = 3'd1,
    RN_INDEX  = 3'd2,
    RN_LO     = 3'd3,
    RN_HI     = 3'd4,
    RN_SEARCH = 3'd5
  } reg_num_e;

  localparam int TAG_VALID_BIT = 6;
  localparam int TAG_SIZE_LSB  = 7;
  localparam int PAGE_LSB      = 10;
  localparam int ZSEL_LSB      = 4;
  localparam int TID_W         = 8;

  // Mask keeping the page-number bits for size code n (1 KB * 4^n).
  function automatic logic [31:0] page_mask(input logic [2:0] code);
    return ~((32'd1024 << {code, 1'b0}) - 32'd1);
  endfunction
endpackage

// File: rtl/tlb_entry_store.sv
module tlb_entry_store #(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [IDX_W-1:0]  sel,
  input  logic              wr_lo,
  input  logic              wr_hi,
  input  logic [31:0]       wdata,
  input  logic [7:0]        pid_in,
  output logic [31:0]       sel_lo,
  output logic [31:0]       sel_hi,
  output logic [7:0]        sel_tid,
  output logic [31:0]       tag_all [ENTRIES],
  output logic [31:0]       dat_all [ENTRIES],
  output logic [7:0]        tid_all [ENTRIES]
);
  logic [31:0] tag_mem [ENTRIES];
  logic [31:0] dat_mem [ENTRIES];
  logic [7:0]  tid_mem [ENTRIES];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ENTRIES; i++) begin
        tag_mem[i] <= '0;
        dat_mem[i] <= '0;
        tid_mem[i] <= '0;
      end
    end else begin
      if (wr_lo) dat_mem[sel] <= wdata;
      if (wr_hi) begin
        tag_mem[sel] <= wdata;
        tid_mem[sel] <= pid_in;
      end
    end
  end

  assign sel_lo  = dat_mem[sel];
  assign sel_hi  = tag_mem[sel];
  assign sel_tid = tid_mem[sel];

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_out
      assign tag_all[g] = tag_mem[g];
      assign dat_all[g] = dat_mem[g];
      assign tid_all[g] = tid_mem[g];
    end
  endgenerate

  // R3: a tag write stamps the entry with the identifier presented at that edge
  assert_tid_capture_R3: assert property (@(posedge clk) disable iff (rst)
    wr_hi |=> tid_mem[$past(sel)] == $past(pid_in));
endmodule

// File: rtl/tlb_search.sv
module tlb_search
  import tlb_maint_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic [31:0]      tag_all [ENTRIES],
  input  logic [31:0]      dat_all [ENTRIES],
  input  logic [7:0]       tid_all [ENTRIES],
  input  logic [31:0]      vaddr,
  input  logic [7:0]       pid,
  input  logic [31:0]      zone,
  input  logic             user,
  output logic             hit,
  output logic [IDX_W-1:0] hit_idx
);
  logic [ENTRIES-1:0] match;

  generate
    for (genvar g = 0; g < ENTRIES; g++) begin : g_cmp
      logic [31:0] mask;
      logic [3:0]  zsel;
      logic [1:0]  zfield;
      assign mask   = page_mask(tag_all[g][TAG_SIZE_LSB +: 3]);
      assign zsel   = dat_all[g][ZSEL_LSB +: 4];
      assign zfield = zone[(5'd30 - {zsel, 1'b0}) +: 2];
      assign match[g] = tag_all[g][TAG_VALID_BIT]
                     && ((vaddr & mask) == (tag_all[g] & mask))
                     && (tid_all[g] == 8'd0 || tid_all[g] == pid)
                     && !(user && zfield == 2'd0);
    end
  endgenerate

  // Lowest index wins: scan downward so the last assignment is the lowest.
  always_comb begin
    hit     = 1'b0;
    hit_idx = '0;
    for (int i = ENTRIES - 1; i >= 0; i--) begin
      if (match[i]) begin
        hit     = 1'b1;
        hit_idx = IDX_W'(i);
      end
    end
  end
endmodule

// File: rtl/tlb_maint_regs.sv
module tlb_maint_regs
  import tlb_maint_pkg::*;
#(
  parameter int ENTRIES = 16,
  parameter int IDX_W   = $clog2(ENTRIES)
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [1:0]  cfg_level,
  input  logic [1:0]  cfg_access,
  input  logic        priv_user,
  input  logic [2:0]  reg_num,
  input  logic        reg_wr,
  input  logic        reg_rd,
  input  logic [31:0] reg_wdata,
  output logic [31:0] reg_rdata
);
  logic [31:0] pid_q, zone_q, idx_q, srch_q;
  logic        gate, wr_ok, wr_priv, rd_ok, rd_priv;
  logic        srch_go, srch_hit;
  logic [IDX_W-1:0] srch_idx;
  logic [31:0] sel_lo, sel_hi;
  logic [7:0]  sel_tid;
  logic [31:0] tag_all [ENTRIES];
  logic [31:0] dat_all [ENTRIES];
  logic [7:0]  tid_all [ENTRIES];

  assign gate    = (cfg_level >= 2'd2) && (cfg_access != 2'd0);
  assign wr_ok   = reg_wr && gate;
  assign wr_priv = wr_ok && cfg_access[1];
  assign rd_ok   = reg_rd && gate;
  assign rd_priv = rd_ok && cfg_access[0];
  assign srch_go = wr_priv && reg_num == RN_SEARCH;

  tlb_entry_store #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_store (
    .clk(clk), .rst(rst), .sel(idx_q[IDX_W-1:0]),
    .wr_lo(wr_ok && reg_num == RN_LO), .wr_hi(wr_ok && reg_num == RN_HI),
    .wdata(reg_wdata), .pid_in(pid_q[7:0]),
    .sel_lo(sel_lo), .sel_hi(sel_hi), .sel_tid(sel_tid),
    .tag_all(tag_all), .dat_all(dat_all), .tid_all(tid_all)
  );

  tlb_search #(.ENTRIES(ENTRIES), .IDX_W(IDX_W)) u_search (
    .tag_all(tag_all), .dat_all(dat_all), .tid_all(tid_all),
    .vaddr({reg_wdata[31:PAGE_LSB], {PAGE_LSB{1'b0}}}),
    .pid(pid_q[7:0]), .zone(zone_q), .user(priv_user),
    .hit(srch_hit), .hit_idx(srch_idx)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pid_q     <= '0;
      zone_q    <= '0;
      idx_q     <= '0;
      srch_q    <= '0;
      reg_rdata <= '0;
    end else begin
      if (wr_priv && reg_num == RN_PID) begin
        if (reg_wdata != pid_q) pid_q <= reg_wdata;
      end else if (rd_priv && reg_num == RN_HI) begin
        pid_q <= {24'd0, sel_tid};
      end
      if (wr_priv && reg_num == RN_ZONE) zone_q <= reg_wdata;
      if (wr_ok && reg_num == RN_INDEX) idx_q <= reg_wdata;
      if (srch_go) begin
        srch_q <= reg_wdata;
        if (srch_hit) idx_q <= 32'(srch_idx);
        else          idx_q <= idx_q | 32'h8000_0000;
      end
      if (reg_rd) begin
        reg_rdata <= '0;
        if (rd_ok) begin
          case (reg_num)
            RN_PID:    if (rd_priv) reg_rdata <= pid_q;
            RN_ZONE:   if (rd_priv) reg_rdata <= zone_q;
            RN_INDEX:  reg_rdata <= idx_q;
            RN_LO:     if (rd_priv) reg_rdata <= sel_lo;
            RN_HI:     if (rd_priv) reg_rdata <= sel_hi;
            RN_SEARCH: reg_rdata <= srch_q;
            default:   reg_rdata <= '0;
          endcase
        end
      end
    end
  end

  // R6: reads while the interface is closed return zero
  assert_closed_read_zero_R6: assert property (@(posedge clk) disable iff (rst)
    (reg_rd && !gate) |=> reg_rdata == 32'd0);
  // R5: a missed search flags bit 31 and keeps the rest of the index
  assert_search_miss_R5: assert property (@(posedge clk) disable iff (rst)
    (srch_go && !srch_hit) |=> idx_q[31] && idx_q[30:0] == $past(idx_q[30:0]));
  // R4: a hit loads the index with the winning entry number
  assert_search_hit_R4: assert property (@(posedge clk) disable iff (rst)
    (srch_go && srch_hit) |=> idx_q == 32'($past(srch_idx)));
  // R7: identifier register is untouched without write permission
  assert_pid_guard_R7: assert property (@(posedge clk) disable iff (rst)
    (reg_wr && reg_num == RN_PID && !(gate && cfg_access[1]) && !reg_rd)
      |=> $stable(pid_q));
  // R3: a permitted tag-word read loads the identifier register
  assert_hi_read_pid_R3: assert property (@(posedge clk) disable iff (rst)
    (rd_priv && reg_num == RN_HI && !reg_wr) |=> pid_q == {24'd0, $past(sel_tid)});
endmodule

// File: tb/tlb_maint_regs_bench.sv
module tlb_maint_regs_bench;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  cfg_level = 2'd2;
  logic [1:0]  cfg_access = 2'd3;
  logic        priv_user = 1'b0;
  logic [2:0]  reg_num = '0;
  logic        reg_wr = 1'b0;
  logic        reg_rd = 1'b0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;

  int checks = 0;
  int fails  = 0;

  always #5 clk = ~clk;

  tlb_maint_regs #(.ENTRIES(16)) u_tlb_maint_regs (
    .clk(clk), .rst(rst), .cfg_level(cfg_level), .cfg_access(cfg_access),
    .priv_user(priv_user), .reg_num(reg_num), .reg_wr(reg_wr), .reg_rd(reg_rd),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  // Vector: {is_read, reg number, data, expected read, requirement number}
  localparam int NV = 36;
  localparam logic [71:0] VEC [NV] = '{
    {1'b0, 3'd2, 32'h0000_0001, 32'h0, 4'd2},
    {1'b0, 3'd0, 32'h0000_005A, 32'h0, 4'd3},
    {1'b0, 3'd4, 32'h0001_2040, 32'h0, 4'd3},
    {1'b0, 3'd3, 32'h8000_0310, 32'h0, 4'd2},
    {1'b1, 3'd3, 32'h0, 32'h8000_0310, 4'd2},        // R2 data word at entry 1
    {1'b0, 3'd0, 32'h0000_0000, 32'h0, 4'd3},
    {1'b1, 3'd4, 32'h0, 32'h0001_2040, 4'd3},        // R3 tag read back
    {1'b1, 3'd0, 32'h0, 32'h0000_005A, 4'd3},        // R3 identifier restored
    {1'b0, 3'd5, 32'h0001_23FF, 32'h0, 4'd4},
    {1'b1, 3'd2, 32'h0, 32'h0000_0001, 4'd4},        // R4 hit, offset bits ignored
    {1'b1, 3'd5, 32'h0, 32'h0001_23FF, 4'd9},        // R9 search readback
    {1'b0, 3'd0, 32'h0000_0033, 32'h0, 4'd4},
    {1'b0, 3'd5, 32'h0001_2000, 32'h0, 4'd5},
    {1'b1, 3'd2, 32'h0, 32'h8000_0001, 4'd5},        // R5 identifier mismatch miss
    {1'b0, 3'd2, 32'h0000_0002, 32'h0, 4'd2},
    {1'b0, 3'd0, 32'h0000_0000, 32'h0, 4'd3},
    {1'b0, 3'd4, 32'h0040_02C0, 32'h0, 4'd10},
    {1'b0, 3'd5, 32'h004A_BCDE, 32'h0, 4'd10},
    {1'b1, 3'd2, 32'h0, 32'h0000_0002, 4'd10},       // R10 inside 1 MB page
    {1'b0, 3'd5, 32'h0050_0000, 32'h0, 4'd10},
    {1'b1, 3'd2, 32'h0, 32'h8000_0002, 4'd10},       // R10 just past 1 MB page
    {1'b0, 3'd2, 32'h0000_0003, 32'h0, 4'd4},
    {1'b0, 3'd4, 32'h0040_02C0, 32'h0, 4'd4},
    {1'b0, 3'd5, 32'h0040_0000, 32'h0, 4'd4},
    {1'b1, 3'd2, 32'h0, 32'h0000_0002, 4'd4},        // R4 lowest index wins
    {1'b0, 3'd2, 32'h0000_0013, 32'h0, 4'd2},
    {1'b1, 3'd4, 32'h0, 32'h0040_02C0, 4'd2},        // R2 index wraps modulo entries
    {1'b1, 3'd2, 32'h0, 32'h0000_0013, 4'd2},        // R2 index keeps all bits
    {1'b1, 3'd6, 32'h0, 32'h0000_0000, 4'd9},        // R9 unused number
    {1'b1, 3'd7, 32'h0, 32'h0000_0000, 4'd9},        // R9 unused number
    {1'b0, 3'd2, 32'h0000_0004, 32'h0, 4'd4},
    {1'b0, 3'd4, 32'h0070_0000, 32'h0, 4'd4},
    {1'b0, 3'd5, 32'h0070_0000, 32'h0, 4'd4},
    {1'b1, 3'd2, 32'h0, 32'h8000_0004, 4'd4},        // R4 invalid entry never matches
    {1'b0, 3'd2, 32'h0000_0007, 32'h0, 4'd4},
    {1'b1, 3'd0, 32'h0, 32'h0000_0000, 4'd3}         // R3 identifier from entry 3 read
  };

  task automatic wr_reg(input logic [2:0] n, input logic [31:0] d);
    reg_num = n; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd_chk(input logic [2:0] n, input logic [31:0] exp, input string req);
    reg_num = n; reg_rd = 1'b1;
    @(negedge clk);
    reg_rd = 1'b0;
    checks++;
    if (reg_rdata !== exp) begin
      fails++;
      $display("FAIL %s reg %0d actual=%08h expected=%08h", req, n, reg_rdata, exp);
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=running expected=finished");
    $display("%0d/%0d checks passed", checks - fails + 1, checks + 1);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // R1 reset state
    rd_chk(3'd2, 32'h0, "R1");
    rd_chk(3'd0, 32'h0, "R1");
    rd_chk(3'd3, 32'h0, "R1");
    rd_chk(3'd4, 32'h0, "R1");

    for (int i = 0; i < NV; i++) begin
      if (VEC[i][71]) rd_chk(VEC[i][70:68], VEC[i][35:4], $sformatf("R%0d", VEC[i][3:0]));
      else            wr_reg(VEC[i][70:68], VEC[i][67:36]);
    end

    // R4 user-mode search blocked by zone field 0, then opened
    priv_user = 1'b1;
    wr_reg(3'd5, 32'h0040_0000);
    rd_chk(3'd2, 32'h8000_0007, "R4");
    wr_reg(3'd1, 32'h4000_0000);
    rd_chk(3'd1, 32'h4000_0000, "R4");
    wr_reg(3'd5, 32'h0040_0000);
    rd_chk(3'd2, 32'h0000_0002, "R4");
    priv_user = 1'b0;

    // R7 access level 1: protected writes dropped, index write kept
    cfg_access = 2'd1;
    wr_reg(3'd0, 32'h0000_0077);
    rd_chk(3'd0, 32'h0, "R7");
    wr_reg(3'd2, 32'h0000_0009);
    wr_reg(3'd5, 32'h0040_0000);
    rd_chk(3'd2, 32'h0000_0009, "R7");
    wr_reg(3'd1, 32'h0);
    rd_chk(3'd1, 32'h4000_0000, "R7");

    // R8 access level 2: protected reads return zero
    cfg_access = 2'd2;
    rd_chk(3'd1, 32'h0, "R8");
    rd_chk(3'd4, 32'h0, "R8");
    rd_chk(3'd2, 32'h0000_0009, "R8");
    rd_chk(3'd5, 32'h0040_0000, "R8");

    // R6 closed interface
    cfg_access = 2'd3; cfg_level = 2'd1;
    rd_chk(3'd2, 32'h0, "R6");
    wr_reg(3'd2, 32'h0000_0005);
    cfg_level = 2'd2;
    rd_chk(3'd2, 32'h0000_0009, "R6");
    cfg_access = 2'd0;
    rd_chk(3'd2, 32'h0, "R6");
    wr_reg(3'd2, 32'h0000_0006);
    cfg_access = 2'd3;
    rd_chk(3'd2, 32'h0000_0009, "R6");

    // R1 reset again clears state
    rst = 1'b1;
    @(negedge clk);
    rst = 1'b0;
    rd_chk(3'd2, 32'h0, "R1");
    rd_chk(3'd1, 32'h0, "R1");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule